// File: doc/BRIEF.md
# Transmit DMA Channel Control and Status Registers

This block is the host-facing register set for eight transmit DMA channels. Each channel has one configuration register, and the host uses it to start the channel, to stop it at once, or to let it finish the current frame before it stops. Each configuration register also holds a request-enable bit. The block turns the stored settings into a run level and a request-enable level for each channel, and a DMA engine outside the block acts on them.

A shared read-only status word gathers the drain state that the DMA engine reports for every channel: whether its buffers are empty and whether it has no outstanding requests. A channel is idle only when both of those are true, and the block also drives that idle flag directly on a pin.

The host side is a plain register port: address, write strobe, write data, and read data. Read data is combinational from the address. Every pin is a level or a single-cycle pulse, and there is no stream data path. For that reason the port has no valid/ready handshake and never applies back-pressure. A write is taken in the clock cycle in which the strobe is high.

Top module: `txdma_ctrl_regs`

## Requirements
- R1: After reset, every configuration register reads 0, and all run, request-enable outputs are 0.
- R2: A configuration register keeps only bits 31:30 (run mode) and bit 3 (request enable). Every other bit reads as 0, whatever value was written.
- R3: Run mode 2'b10 drives the channel's run output high from the clock edge that takes the write. Modes 2'b00 and 2'b11 hold it low. Writing 0 stops a running channel.
- R4: Bit 3 of a channel's configuration register drives that channel's request-enable output. The request-enable output is independent of the run mode.
- R5: In run mode 2'b01, the run output stays high until the channel's end-of-frame input is sampled high at a clock edge. After that edge the run output is low and the mode field reads 2'b00. The request-enable bit is unchanged.
- R6: An end-of-frame pulse on a channel whose mode is not 2'b01 changes nothing.
- R7: If a host write to a channel and that channel's end-of-frame pulse arrive in the same cycle, the written value is stored.
- R8: The status word carries buffers-empty for channel i in bit 24+i and no-pending-request for channel i in bit 16+i. Bits 15:0 read 0. The word follows the inputs in the same cycle.
- R9: A write to the status address changes no register.
- R10: A channel's idle output is high only when both its buffers-empty input and its no-pending-request input are high.
- R11: A read from any unmapped address returns 0, and a write to one changes no register.
- R12: The configuration register of channel n sits at byte address 0x20*n. The status word sits at 0x100. Only exact matches are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Host byte address |
| reg_wr_en | input | 1 | Host write strobe |
| reg_wr_data | input | 32 | Host write data |
| reg_rd_data | output | 32 | Read data for reg_addr (combinational) |
| chan_eof_i | input | 8 | End-of-frame pulse per channel |
| chan_buf_empty_i | input | 8 | Channel buffers empty |
| chan_no_pend_i | input | 8 | Channel has no pending requests |
| chan_run_o | output | 8 | Channel run level |
| chan_req_en_o | output | 8 | Channel request enable |
| chan_idle_o | output | 8 | Buffers empty and no pending requests |

## Verification
A configuration write or an end-of-frame pulse is sampled at one clock edge, and its effect on the run and request-enable outputs and on the readback is due right after that edge. The bench therefore drives stimulus on the falling edge, updates its model at the rising edge, and compares shortly after that edge. The status word, the idle outputs and all read data are combinational. The bench checks them in the same cycle, a nanosecond after it sets the address or the drain inputs, and keeps every read inside the low half of the clock.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam int unsigned N_CH      = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned MODE_LSB  = 30;
  localparam int unsigned REQ_BIT   = 3;
  localparam int unsigned EMPTY_LSB = 24;
  localparam int unsigned NOPEND_LSB = 16;
  localparam logic [DATA_W-1:0] CFG_KEEP_MASK = 32'hC000_0008;

  typedef enum logic [1:0] {
    RM_OFF       = 2'b00,
    RM_PAUSE_EOF = 2'b01,
    RM_RUN       = 2'b10,
    RM_RSVD      = 2'b11
  } run_mode_e;
endpackage

// File: rtl/txdma_addr_dec.sv
module txdma_addr_dec #(
  parameter int unsigned N_CH     = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CFG_BASE = 0,
  parameter int unsigned STRIDE   = 32,
  parameter int unsigned STAT_OFF = 256
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_CH-1:0]   cfg_sel,
  output logic              stat_sel
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFF);

  for (genvar g = 0; g < N_CH; g++) begin : g_cfg
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(CFG_BASE + g * STRIDE);
    assign cfg_sel[g] = (addr == CH_ADDR);
  end

  assign stat_sel = (addr == STAT_ADDR);
endmodule

// File: rtl/txdma_chan_cfg.sv
module txdma_chan_cfg
  import txdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [1:0]        wr_mode,
  input  logic              wr_req,
  input  logic              eof,
  output logic              run_o,
  output logic              req_en_o,
  output logic [DATA_W-1:0] cfg_rd
);
  run_mode_e mode_q;
  logic      req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RM_OFF;
      req_q  <= 1'b0;
    end else if (wr_sel) begin
      mode_q <= run_mode_e'(wr_mode);
      req_q  <= wr_req;
    end else if (mode_q == RM_PAUSE_EOF && eof) begin
      mode_q <= RM_OFF;
    end
  end

  always_comb begin
    unique case (mode_q)
      RM_RUN, RM_PAUSE_EOF: run_o = 1'b1;
      default:              run_o = 1'b0;
    endcase
  end

  assign req_en_o = req_q;

  always_comb begin
    cfg_rd = '0;
    cfg_rd[MODE_LSB +: 2] = mode_q;
    cfg_rd[REQ_BIT]       = req_q;
  end

  assert_pause_eof_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RM_PAUSE_EOF && eof && !wr_sel) |=> (mode_q == RM_OFF && !run_o));
  assert_pause_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RM_PAUSE_EOF && !eof && !wr_sel) |=> run_o);
  assert_eof_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != RM_PAUSE_EOF && !wr_sel) |=> ($stable(mode_q) && $stable(req_q)));
  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (cfg_rd[MODE_LSB +: 2] == $past(wr_mode) && req_en_o == $past(wr_req)));
endmodule

// File: rtl/txdma_status.sv
module txdma_status
  import txdma_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic [NCH-1:0]    buf_empty,
  input  logic [NCH-1:0]    no_pend,
  output logic [DATA_W-1:0] stat_word,
  output logic [NCH-1:0]    idle
);
  always_comb begin
    stat_word = '0;
    for (int i = 0; i < NCH; i++) begin
      stat_word[EMPTY_LSB + i]  = buf_empty[i];
      stat_word[NOPEND_LSB + i] = no_pend[i];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_idle
    assign idle[g] = buf_empty[g] & no_pend[g];
  end
endmodule

// File: rtl/txdma_ctrl_regs.sv
module txdma_ctrl_regs
  import txdma_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CFG_BASE = 0,
  parameter int unsigned STRIDE   = 32,
  parameter int unsigned STAT_OFF = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wr_data,
  output logic [31:0]       reg_rd_data,
  input  logic [7:0]        chan_eof_i,
  input  logic [7:0]        chan_buf_empty_i,
  input  logic [7:0]        chan_no_pend_i,
  output logic [7:0]        chan_run_o,
  output logic [7:0]        chan_req_en_o,
  output logic [7:0]        chan_idle_o
);
  logic [N_CH-1:0]   cfg_sel;
  logic              stat_sel;
  logic [DATA_W-1:0] cfg_rd [N_CH];
  logic [DATA_W-1:0] stat_word;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^{reg_wr_data[29:4], reg_wr_data[2:0]};

  txdma_addr_dec #(
    .N_CH(N_CH), .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE),
    .STRIDE(STRIDE), .STAT_OFF(STAT_OFF)
  ) u_dec (
    .addr(reg_addr), .cfg_sel(cfg_sel), .stat_sel(stat_sel)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    txdma_chan_cfg u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_sel(reg_wr_en & cfg_sel[g]),
      .wr_mode(reg_wr_data[MODE_LSB +: 2]),
      .wr_req(reg_wr_data[REQ_BIT]),
      .eof(chan_eof_i[g]),
      .run_o(chan_run_o[g]),
      .req_en_o(chan_req_en_o[g]),
      .cfg_rd(cfg_rd[g])
    );
  end

  txdma_status #(.NCH(N_CH)) u_stat (
    .buf_empty(chan_buf_empty_i), .no_pend(chan_no_pend_i),
    .stat_word(stat_word), .idle(chan_idle_o)
  );

  always_comb begin
    reg_rd_data = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (cfg_sel[i]) reg_rd_data = cfg_rd[i];
    end
    if (stat_sel) reg_rd_data = stat_word;
  end

  assert_sel_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_sel, stat_sel}));
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_sel) |-> ((reg_rd_data & ~CFG_KEEP_MASK) == '0));
  assert_status_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel |-> (reg_rd_data == {chan_buf_empty_i, chan_no_pend_i, 16'h0000}));
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|cfg_sel) && !stat_sel) |-> (reg_rd_data == '0));
  assert_idle_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_idle_o & ~(chan_buf_empty_i & chan_no_pend_i)) == '0);
endmodule

// File: tb/test_txdma_ctrl_regs.sv
`timescale 1ns/1ps
module test_txdma_ctrl_regs;
  localparam real CLK_PER = 20.0;
  localparam logic [11:0] STAT_A = 12'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic [7:0]  chan_eof_i = '0;
  logic [7:0]  chan_buf_empty_i = '0;
  logic [7:0]  chan_no_pend_i = '0;
  logic [7:0]  chan_run_o, chan_req_en_o, chan_idle_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] m_mode [8];
  logic       m_req  [8];

  always #(CLK_PER/2) clk = ~clk;

  txdma_ctrl_regs i_txdma_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .chan_eof_i(chan_eof_i), .chan_buf_empty_i(chan_buf_empty_i),
    .chan_no_pend_i(chan_no_pend_i), .chan_run_o(chan_run_o),
    .chan_req_en_o(chan_req_en_o), .chan_idle_o(chan_idle_o)
  );

  function automatic int cfg_idx(logic [11:0] a);
    for (int c = 0; c < 8; c++) if (a == 12'(c * 32)) return c;
    return -1;
  endfunction

  function automatic logic [31:0] exp_cfg(int c);
    return {m_mode[c], 26'd0, m_req[c], 3'd0};
  endfunction

  function automatic logic [7:0] exp_run();
    logic [7:0] r;
    for (int c = 0; c < 8; c++) r[c] = (m_mode[c] == 2'b10) || (m_mode[c] == 2'b01);
    return r;
  endfunction

  function automatic logic [7:0] exp_req();
    logic [7:0] r;
    for (int c = 0; c < 8; c++) r[c] = m_req[c];
    return r;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_cycle(logic wr, logic [11:0] a, logic [31:0] d, logic [7:0] eof,
                          logic [7:0] emp, logic [7:0] np);
    int ci;
    @(negedge clk);
    reg_wr_en = wr; reg_addr = a; reg_wr_data = d; chan_eof_i = eof;
    chan_buf_empty_i = emp; chan_no_pend_i = np;
    @(posedge clk);
    ci = cfg_idx(a);
    for (int c = 0; c < 8; c++) begin
      if (wr && ci == c) begin
        m_mode[c] = d[31:30];
        m_req[c]  = d[3];
      end else if (m_mode[c] == 2'b01 && eof[c]) begin
        m_mode[c] = 2'b00;
      end
    end
    #1;
    reg_wr_en = 1'b0; chan_eof_i = '0;
  endtask

  task automatic check_all(string tag);
    @(negedge clk);
    chk({24'd0, chan_run_o}, {24'd0, exp_run()}, {tag, " run R3 R5"});
    chk({24'd0, chan_req_en_o}, {24'd0, exp_req()}, {tag, " req R4"});
    chk({24'd0, chan_idle_o}, {24'd0, chan_buf_empty_i & chan_no_pend_i}, {tag, " idle R10"});
    for (int c = 0; c < 8; c++) begin
      reg_addr = 12'(c * 32);
      #1;
      chk(reg_rd_data, exp_cfg(c), {tag, " cfg R2 R12"});
    end
    reg_addr = STAT_A;
    #0.5;
    chk(reg_rd_data, {chan_buf_empty_i, chan_no_pend_i, 16'h0}, {tag, " status R8"});
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rd_data, exp, req);
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < 8; c++) begin m_mode[c] = 2'b00; m_req[c] = 1'b0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check_all("R1 reset");

    // R3 R4 R12 normal start on channel 0
    do_cycle(1, 12'h000, 32'h8000_0008, 8'h00, 8'h00, 8'h00);
    check_all("R3 start ch0");
    chk({31'd0, chan_run_o[0]}, 32'd1, "R3 ch0 runs");

    // R2 reserved bits masked, R3 mode 11 is off
    do_cycle(1, 12'h0A0, 32'hFFFF_FFFF, 8'h00, 8'h00, 8'h00);
    rd_chk(12'h0A0, 32'hC000_0008, "R2 ch5 readback");
    chk({31'd0, chan_run_o[5]}, 32'd0, "R3 mode 11 off");
    chk({31'd0, chan_req_en_o[5]}, 32'd1, "R4 req independent of mode");

    // R5 pause at end of frame on ch2
    do_cycle(1, 12'h040, 32'h4000_0008, 8'h00, 8'h00, 8'h00);
    do_cycle(0, 12'h000, 32'h0, 8'h00, 8'h00, 8'h00);
    do_cycle(0, 12'h000, 32'h0, 8'h00, 8'h00, 8'h00);
    chk({31'd0, chan_run_o[2]}, 32'd1, "R5 runs until eof");
    do_cycle(0, 12'h000, 32'h0, 8'h05, 8'h00, 8'h00);
    chk({31'd0, chan_run_o[2]}, 32'd0, "R5 stops after eof");
    chk({31'd0, chan_run_o[0]}, 32'd1, "R6 eof ignored in run mode");
    rd_chk(12'h040, 32'h0000_0008, "R5 mode reads 00, req kept");
    check_all("R5 R6");

    // R7 write and eof together
    do_cycle(1, 12'h060, 32'h4000_0008, 8'h00, 8'h00, 8'h00);
    do_cycle(1, 12'h060, 32'h4000_0000, 8'h08, 8'h00, 8'h00);
    rd_chk(12'h060, 32'h4000_0000, "R7 write wins");
    chk({31'd0, chan_run_o[3]}, 32'd1, "R7 still running");

    // R8 R10 status
    do_cycle(0, 12'h000, 32'h0, 8'h00, 8'hA5, 8'h3C);
    rd_chk(STAT_A, 32'hA53C_0000, "R8 status word");
    chk({24'd0, chan_idle_o}, 32'h24, "R10 idle");

    // R9 status write ignored
    do_cycle(1, STAT_A, 32'hFFFF_FFFF, 8'h00, 8'hA5, 8'h3C);
    rd_chk(STAT_A, 32'hA53C_0000, "R9 status write ignored");
    check_all("R9");

    // R11 unmapped
    do_cycle(1, 12'h004, 32'hFFFF_FFFF, 8'h00, 8'h00, 8'h00);
    do_cycle(1, 12'h0E4, 32'hFFFF_FFFF, 8'h00, 8'h00, 8'h00);
    do_cycle(1, 12'h200, 32'hFFFF_FFFF, 8'h00, 8'h00, 8'h00);
    do_cycle(1, 12'h101, 32'hFFFF_FFFF, 8'h00, 8'h00, 8'h00);
    rd_chk(12'h004, 32'h0, "R11 unmapped read");
    rd_chk(12'h200, 32'h0, "R11 unmapped read high");
    check_all("R11 no effect");

    // R3 stop by writing zero
    do_cycle(1, 12'h000, 32'h0, 8'h00, 8'h00, 8'h00);
    chk({31'd0, chan_run_o[0]}, 32'd0, "R3 write 0 stops");
    check_all("R3 stop");

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int unsigned op;
      logic [11:0] a;
      logic [31:0] d;
      op = $urandom % 8;
      d  = $urandom;
      if (op < 4) a = 12'(($urandom % 8) * 32);
      else if (op == 5) a = STAT_A;
      else begin
        a = 12'($urandom % 1024);
        if (cfg_idx(a) >= 0 || a == STAT_A) a = a + 12'd4;
      end
      do_cycle(op != 4 && op != 7, a, d, 8'($urandom), 8'($urandom), 8'($urandom));
      check_all("random R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule